// File: doc/BRIEF.md
# Audio Routing Matrix Configurator

This block keeps the routing table of an audio crossbar. Every destination endpoint holds exactly one source endpoint, and any source may be given to as many destinations as software likes. The table is presented continuously on a wide output bus, one slice per destination, so that a sample-datapath multiplexer can use it to pick its inputs. The datapath itself lies outside the block.

Endpoint codes are eleven bits wide, but only two fields carry meaning: a 3-bit group in code bits 10:8 and a 5-bit index in code bits 4:0. Software reaches the block through four narrow registers. Two of them stage the destination's group and index, and one stages the source group. A write to the source-index register commits the staged source to the staged destination in one step. To read a mapping, software stages a destination and then reads the two source registers. It rebuilds the full code as (group << 8) | index. A write that sets bits outside its field is discarded and latches a sticky error flag.

Top module: `route_matrix_cfg`

## Requirements
- R1: After reset every table entry is zero (the silence source), the three staging registers are zero and `cfg_err` is low.
- R2: Register selects on `reg_addr` are: 0 destination group, 1 destination index, 2 source group, 3 source index. A group sits in `reg_wdata[2:0]` and an index in `reg_wdata[4:0]`. Reads at 0 and 1 return the staged destination group and index, zero-extended.
- R3: A write to select 0 or 2 with any of `reg_wdata[7:3]` set is dropped (the staging register is left unchanged) and sets `cfg_err`.
- R4: A write to select 3 with any of `reg_wdata[7:5]` set is dropped. No table entry changes, and `cfg_err` is set.
- R5: `cfg_err` stays high once set, until reset.
- R6: A valid write to select 3 loads {staged source group, `reg_wdata[4:0]`} into the entry numbered group*32+index of the staged destination. That entry appears at `route_map[entry*8 +: 8]` (group in the upper 3 bits) from the next clock edge.
- R7: Writes to selects 0, 1 and 2, and cycles without a write, leave `route_map` unchanged.
- R8: A read at select 2 returns the stored source group of the staged destination's entry, and a read at select 3 returns its stored source index, both zero-extended. `reg_rdata` follows `reg_addr` within the same cycle.
- R9: One source may be committed to several destinations. Committing a new source to one destination changes only that destination's entry.
- R10: The staged source group persists after a commit, so repeated index writes reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current select |
| cfg_err | output | 1 | Sticky flag for dropped out-of-range writes |
| route_map | output | 2048 | Source code of every destination, 8 bits each |

## Verification
The bench programs a single source into destinations at both ends of the table and in its middle. A design that decoded the entry number wrongly, or that wrote every entry at once, would corrupt the neighbouring slices, and the per-cycle comparison of the whole map catches this. Out-of-range group and index writes are issued between valid ones. A design that masked the data instead of dropping it would either change a staging register or commit a bogus entry. The bench also checks that the error flag survives good traffic. Staging writes are interleaved with map checks to expose a design that commits early, and reuse of the staged source group across several commits exposes a design that clears it after each commit.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

  typedef enum logic [1:0] {
    SEL_DST_GRP = 2'd0,
    SEL_DST_IDX = 2'd1,
    SEL_SRC_GRP = 2'd2,
    SEL_SRC_IDX = 2'd3
  } rmx_sel_e;

  // True when no bit of v at or above position w is set.
  function automatic logic fits_field(input logic [31:0] v, input int unsigned w);
    return (v >> w) == 32'd0;
  endfunction

  // Group selects take the narrow field, index selects the wider one.
  function automatic logic is_group_sel(input logic [1:0] sel);
    return (sel == SEL_DST_GRP) || (sel == SEL_SRC_GRP);
  endfunction

endpackage

// File: rtl/rmx_regport.sv
module rmx_regport
  import rmx_pkg::*;
#(
  parameter int GRP_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [GRP_W-1:0]  stg_dst_grp,
  output logic [IDX_W-1:0]  stg_dst_idx,
  output logic [GRP_W-1:0]  stg_src_grp,
  output logic              commit_ev,
  output logic [GRP_W+IDX_W-1:0] commit_code,
  output logic              bad_wr_ev,
  output logic              err_flag
);
  localparam int SEL_W = GRP_W + IDX_W;

  logic       in_range;
  logic       wr_ok;
  rmx_sel_e   sel;

  assign sel         = rmx_sel_e'(reg_addr);
  assign in_range    = is_group_sel(reg_addr) ? fits_field(32'(reg_wdata), GRP_W)
                                              : fits_field(32'(reg_wdata), IDX_W);
  assign wr_ok       = reg_wr && in_range;
  assign bad_wr_ev   = reg_wr && !in_range;
  assign commit_ev   = wr_ok && (sel == SEL_SRC_IDX);
  assign commit_code = SEL_W'({stg_src_grp, reg_wdata[IDX_W-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_dst_grp <= '0;
      stg_dst_idx <= '0;
      stg_src_grp <= '0;
      err_flag    <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (sel)
          SEL_DST_GRP: stg_dst_grp <= reg_wdata[GRP_W-1:0];
          SEL_DST_IDX: stg_dst_idx <= reg_wdata[IDX_W-1:0];
          SEL_SRC_GRP: stg_src_grp <= reg_wdata[GRP_W-1:0];
          default: ;
        endcase
      end
      if (bad_wr_ev) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rmx_table.sv
module rmx_table #(
  parameter int SEL_W   = 8,
  parameter int NUM_DST = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_dst,
  input  logic [SEL_W-1:0]         wr_code,
  output logic [NUM_DST*SEL_W-1:0] map_flat
);
  for (genvar d = 0; d < NUM_DST; d++) begin : g_ent
    logic [SEL_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (wr_en && (wr_dst == SEL_W'(d)))
        ent_q <= wr_code;
    end
    assign map_flat[d*SEL_W +: SEL_W] = ent_q;
  end
endmodule

// File: rtl/rmx_readmux.sv
module rmx_readmux
  import rmx_pkg::*;
#(
  parameter int GRP_W   = 3,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 8,
  parameter int NUM_DST = 256
) (
  input  logic [1:0]                          sel,
  input  logic [GRP_W-1:0]                    dst_grp,
  input  logic [IDX_W-1:0]                    dst_idx,
  input  logic [NUM_DST*(GRP_W+IDX_W)-1:0]    map_flat,
  output logic [DATA_W-1:0]                   rdata
);
  localparam int SEL_W = GRP_W + IDX_W;

  logic [SEL_W-1:0] ent [NUM_DST];
  logic [SEL_W-1:0] hit;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_unpack
    assign ent[d] = map_flat[d*SEL_W +: SEL_W];
  end

  assign hit = ent[{dst_grp, dst_idx}];

  always_comb begin
    case (rmx_sel_e'(sel))
      SEL_DST_GRP: rdata = DATA_W'(dst_grp);
      SEL_DST_IDX: rdata = DATA_W'(dst_idx);
      SEL_SRC_GRP: rdata = DATA_W'(hit[SEL_W-1:IDX_W]);
      default:     rdata = DATA_W'(hit[IDX_W-1:0]);
    endcase
  end
endmodule

// File: rtl/route_matrix_cfg.sv
module route_matrix_cfg #(
  parameter int GRP_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      reg_wr,
  input  logic [1:0]                                reg_addr,
  input  logic [DATA_W-1:0]                         reg_wdata,
  output logic [DATA_W-1:0]                         reg_rdata,
  output logic                                      cfg_err,
  output logic [(1<<(GRP_W+IDX_W))*(GRP_W+IDX_W)-1:0] route_map
);
  localparam int SEL_W   = GRP_W + IDX_W;
  localparam int NUM_DST = 1 << SEL_W;

  logic [GRP_W-1:0] stg_dst_grp;
  logic [IDX_W-1:0] stg_dst_idx;
  logic [GRP_W-1:0] stg_src_grp;
  logic [SEL_W-1:0] stg_dst;
  logic [SEL_W-1:0] commit_code;
  logic             commit_ev;
  logic             bad_wr_ev;

  assign stg_dst = {stg_dst_grp, stg_dst_idx};

  rmx_regport #(.GRP_W(GRP_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .stg_dst_grp (stg_dst_grp),
    .stg_dst_idx (stg_dst_idx),
    .stg_src_grp (stg_src_grp),
    .commit_ev   (commit_ev),
    .commit_code (commit_code),
    .bad_wr_ev   (bad_wr_ev),
    .err_flag    (cfg_err)
  );

  rmx_table #(.SEL_W(SEL_W), .NUM_DST(NUM_DST)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_ev),
    .wr_dst   (stg_dst),
    .wr_code  (commit_code),
    .map_flat (route_map)
  );

  rmx_readmux #(.GRP_W(GRP_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_DST(NUM_DST)) u_rd (
    .sel      (reg_addr),
    .dst_grp  (stg_dst_grp),
    .dst_idx  (stg_dst_idx),
    .map_flat (route_map),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/rmx_checker.sv
module rmx_checker #(
  parameter int GRP_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic                                        reg_wr,
  input logic [1:0]                                  reg_addr,
  input logic [DATA_W-1:0]                           reg_wdata,
  input logic [DATA_W-1:0]                           reg_rdata,
  input logic                                        cfg_err,
  input logic [(1<<(GRP_W+IDX_W))*(GRP_W+IDX_W)-1:0] route_map,
  input logic [GRP_W+IDX_W-1:0]                      stg_dst,
  input logic [GRP_W-1:0]                            stg_src_grp,
  input logic                                        commit_ev,
  input logic                                        bad_wr_ev
);
  localparam int SEL_W   = GRP_W + IDX_W;
  localparam int NUM_DST = 1 << SEL_W;

  logic [SEL_W-1:0] ent [NUM_DST];
  logic [SEL_W-1:0] cur_ent;
  for (genvar d = 0; d < NUM_DST; d++) begin : g_unpack
    assign ent[d] = route_map[d*SEL_W +: SEL_W];
  end
  assign cur_ent = ent[stg_dst];

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R5

  AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_ev |=> cfg_err); // R3

  AST_BAD_INDEX_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && (reg_wdata >> IDX_W) != '0) |-> !commit_ev); // R4

  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(route_map)); // R7

  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> (cur_ent == $past({stg_src_grp, reg_wdata[IDX_W-1:0]}))); // R6

  AST_GROUP_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> ((reg_rdata >> GRP_W) == '0)); // R8
endmodule

bind route_matrix_cfg rmx_checker #(.GRP_W(GRP_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .cfg_err     (cfg_err),
  .route_map   (route_map),
  .stg_dst     (stg_dst),
  .stg_src_grp (stg_src_grp),
  .commit_ev   (commit_ev),
  .bad_wr_ev   (bad_wr_ev)
);

// File: tb/route_matrix_cfg_test.sv
`timescale 1ns/1ps
module route_matrix_cfg_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [7:0]    reg_wdata = 8'd0;
  logic [7:0]    reg_rdata;
  logic          cfg_err;
  logic [2047:0] route_map;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model: per-destination group/index arrays and staging integers.
  int m_grp [256];
  int m_idx [256];
  int m_dg, m_di, m_sg;
  bit m_err;

  always #2.5 clk = ~clk;

  route_matrix_cfg uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_err(cfg_err),
    .route_map(route_map)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin m_grp[i] = 0; m_idx[i] = 0; end
      m_dg = 0; m_di = 0; m_sg = 0; m_err = 0;
    end else if (reg_wr) begin
      int v;
      v = reg_wdata;
      case (reg_addr)
        2'd0: if (v < 8)  m_dg = v; else m_err = 1;
        2'd1: if (v < 32) m_di = v; else m_err = 1;
        2'd2: if (v < 8)  m_sg = v; else m_err = 1;
        default: if (v < 32) begin
          m_grp[m_dg*32 + m_di] = m_sg;
          m_idx[m_dg*32 + m_di] = v;
        end else m_err = 1;
      endcase
    end
  end

  // Every-cycle comparison of the registered outputs.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int bad;
      bad = -1;
      for (int d = 0; d < 256; d++)
        if (int'(route_map[d*8 +: 8]) != m_grp[d]*32 + m_idx[d] && bad < 0) bad = d;
      checks++;
      if (bad >= 0) begin
        fails++;
        $display("FAIL R6 entry %0d actual %0h expected %0h", bad,
                 route_map[bad*8 +: 8], m_grp[bad]*32 + m_idx[bad]);
      end
      checks++;
      if (cfg_err !== m_err) begin
        fails++;
        $display("FAIL R5 cfg_err actual %0b expected %0b", cfg_err, m_err);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'(a);
    #1;
    checks++;
    if (int'(reg_rdata) != exp) begin
      fails++;
      $display("FAIL %s select %0d actual %0h expected %0h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic map_dst(input int dg, input int di, input int sg, input int si);
    wr(0, dg); wr(1, di); wr(2, sg); wr(3, si);
  endtask

  // Stage a destination and read its source back as a full code.
  task automatic read_code(input int dg, input int di, input int exp_code, input string tag);
    int hi, lo;
    wr(0, dg); wr(1, di);
    @(negedge clk); reg_addr = 2'd2; #1; hi = reg_rdata;
    @(negedge clk); reg_addr = 2'd3; #1; lo = reg_rdata;
    checks++;
    if (((hi << 8) | lo) != exp_code) begin
      fails++;
      $display("FAIL %s code actual %0h expected %0h", tag, (hi << 8) | lo, exp_code);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    expect_bit(cfg_err, 1'b0, "R1 err after reset");
    checks++;
    if (route_map !== '0) begin fails++; $display("FAIL R1 map actual nonzero expected 0"); end
    for (int a = 0; a < 4; a++) rd_expect(a, 0, "R1");

    // R2, R6, R7, R8: single mapping
    wr(0, 2); wr(1, 7); wr(2, 5);
    checks++;
    if (route_map !== '0) begin fails++; $display("FAIL R7 map changed before commit actual nonzero expected 0"); end
    rd_expect(0, 2, "R2"); rd_expect(1, 7, "R2");
    rd_expect(2, 0, "R8 before commit");
    wr(3, 19);
    checks++;
    if (route_map[(2*32+7)*8 +: 8] !== 8'({3'd5, 5'd19})) begin
      fails++; $display("FAIL R6 slice actual %0h expected %0h", route_map[(2*32+7)*8 +: 8], {3'd5, 5'd19});
    end
    rd_expect(2, 5, "R8"); rd_expect(3, 19, "R8");
    read_code(2, 7, (5 << 8) | 19, "R8");

    // R9: one source to many, then replace one
    map_dst(0, 0, 1, 4); map_dst(7, 31, 1, 4); map_dst(3, 15, 1, 4);
    read_code(0, 0, (1 << 8) | 4, "R9");
    read_code(7, 31, (1 << 8) | 4, "R9");
    map_dst(7, 31, 6, 2);
    read_code(7, 31, (6 << 8) | 2, "R9");
    read_code(0, 0, (1 << 8) | 4, "R9");
    read_code(3, 15, (1 << 8) | 4, "R9");

    // R10: staged source group reused across commits
    wr(2, 4); wr(0, 1); wr(1, 10); wr(3, 9); wr(1, 11); wr(3, 8);
    read_code(1, 10, (4 << 8) | 9, "R10");
    read_code(1, 11, (4 << 8) | 8, "R10");

    // R3: out-of-range group write dropped
    expect_bit(cfg_err, 1'b0, "R3 err before");
    wr(0, 6); wr(0, 8'h08);
    expect_bit(cfg_err, 1'b1, "R3 err set");
    rd_expect(0, 6, "R3 staging kept");
    wr(2, 8'hF3);
    rd_expect(2, 0, "R3 source group unaffected read");

    // R4: out-of-range index commit dropped
    wr(0, 2); wr(1, 7); wr(3, 8'h20);
    rd_expect(3, 19, "R4 entry kept");
    rd_expect(2, 5, "R4 entry kept");

    // R5: sticky through good traffic
    map_dst(5, 5, 2, 2);
    expect_bit(cfg_err, 1'b1, "R5 sticky");

    // Mixed random traffic with occasional bad writes
    for (int n = 0; n < 400; n++) begin
      int a, d;
      a = $urandom_range(3, 0);
      d = ($urandom_range(9, 0) == 0) ? $urandom_range(255, 0)
                                       : ((a == 0 || a == 2) ? $urandom_range(7, 0) : $urandom_range(31, 0));
      wr(a, d);
    end
    rd_expect(2, m_grp[m_dg*32 + m_di], "R8 after sweep");
    rd_expect(3, m_idx[m_dg*32 + m_di], "R8 after sweep");

    // R1: reset clears everything again
    do_reset();
    @(negedge clk);
    expect_bit(cfg_err, 1'b0, "R1 err after second reset");
    checks++;
    if (route_map !== '0) begin fails++; $display("FAIL R1 map actual nonzero expected 0"); end

    done = 1'b1;
    report();
    $finish;
  end
endmodule